// File: doc/BRIEF.md
# Record-then-Playback Memory Sequencer

This block runs a sampled-data recorder around an external byte-wide static RAM. After reset it is in the record state. Once per clock it drives the next RAM address, passes the current sample byte to the RAM write-data bus, and pulses the write strobe during the low half of the clock. The address is already stable by then, because it changed at the preceding rising edge. When the address counter reaches all ones, its carry moves the sequencer into the play state, and the address wraps to zero. In the play state the same addresses are stepped through with the read strobe pulsed in the low half of each clock. The byte the RAM returns is captured at the next rising edge and presented on a playback port, together with a one-cycle valid flag.

The address counter is built from cascaded byte-wide stages. Each stage counts only when every lower stage is full, and a narrower final stage covers widths that are not a multiple of eight. A 17-bit address therefore uses two full stages and one single-bit stage.

After one full playback pass the sequencer takes one of two paths, chosen by a parameter:
- It parks in an idle state with both strobes low.
- It replays from address zero indefinitely.

There are three named states:
- `SEQ_RECORD`: write pass.
- `SEQ_PLAY`: read pass.
- `SEQ_IDLE`: parked.

There are four named transitions:
- *wrap-to-play*: `SEQ_RECORD` to `SEQ_PLAY`, taken on carry.
- *replay*: `SEQ_PLAY` to `SEQ_PLAY`, taken on carry when looping.
- *finish*: `SEQ_PLAY` to `SEQ_IDLE`, taken on carry when not looping.
- *park*: `SEQ_IDLE` to `SEQ_IDLE`, always.

Top module: `rec_play_seq`

## Requirements
- R1: While reset is asserted, the address is zero, the play-mode output is 0 and both strobes are low. The first cycle after reset is a record cycle at address zero.
- R2: In the record state the address advances by exactly one at each rising clock edge, from zero up to all ones. The write-data bus carries the sample input.
- R3: The write strobe is high only during the low half of the clock in the record state. It is low throughout every high half of the clock.
- R4: The read strobe is high only during the low half of the clock in the play state. The two strobes are never high together.
- R5: The carry output is 1 exactly while the address equals all ones in the record or play state.
- R6: On the rising edge at which the record address is all ones, the sequencer enters the play state, the play-mode output becomes 1 and the address becomes zero. No write strobe occurs after that edge.
- R7: Playback returns the recorded bytes in recording order. The byte read at an address appears on the playback port with the valid flag high for the one clock after its read strobe.
- R8: With looping off, the rising edge that ends the last read moves the sequencer to idle. In idle both strobes stay low, the address stays zero, play mode stays 1 and valid stays low.
- R9: With looping on, playback repeats from address zero without a gap, and the read order is the same in every pass.
- R10: For address widths above eight bits, the cascaded stages count through every address up to all ones, and carry appears only at the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; strobes use its low half |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_W | Incoming sample byte |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data |
| ram_we_o | output | 1 | Write strobe, active high |
| ram_re_o | output | 1 | Read strobe, active high |
| play_mode_o | output | 1 | 0 while recording, 1 once playback has begun |
| carry_o | output | 1 | Counter at all ones |
| play_data_o | output | DATA_W | Byte returned during playback |
| play_valid_o | output | 1 | play_data_o holds a fresh byte |

## Verification
The bench watches the hand-over from record to play. A design that toggled the mode one edge late would write a stray byte over address zero. A design that did not wrap the address would start playback at a wrong location, and either fault makes the first played byte mismatch. Every half clock is checked so that a strobe leaking into the high phase, or both strobes rising together, is caught at once. After the last read, a non-looping design that kept counting would show read strobes or valid pulses in idle. A looping design with a broken stage cascade, run at a 10-bit address, would raise carry at 255 instead of 1023 and enter playback too early.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;

    typedef enum logic [1:0] {
        SEQ_RECORD = 2'd0,
        SEQ_PLAY   = 2'd1,
        SEQ_IDLE   = 2'd2
    } seq_state_t;

    localparam int STAGE_W = 8;

endpackage

// File: rtl/rps_addr_counter.sv
`timescale 1ns/1ps
module rps_addr_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    output logic [ADDR_W-1:0] addr_o,
    output logic              carry_o
);
    import rps_pkg::*;

    localparam int NSTAGE = (ADDR_W + STAGE_W - 1) / STAGE_W;

    // full_chain[s]: every stage below s holds all ones
    logic [NSTAGE:0] full_chain;
    assign full_chain[0] = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        localparam int LO = s * STAGE_W;
        localparam int W  = ((ADDR_W - LO) > STAGE_W) ? STAGE_W : (ADDR_W - LO);

        logic [W-1:0] stg_q;
        logic         stg_full;
        logic         stg_step;

        assign stg_full = &stg_q;
        assign stg_step = count_en & full_chain[s];
        assign full_chain[s+1] = full_chain[s] & stg_full;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else if (stg_step) begin
                stg_q <= stg_q + 1'b1;
            end
        end

        assign addr_o[LO +: W] = stg_q;
    end

    assign carry_o = full_chain[NSTAGE];

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && carry_o) |=> addr_o == '0);

    a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(addr_o));

endmodule

// File: rtl/rps_mode_fsm.sv
`timescale 1ns/1ps
module rps_mode_fsm #(
    parameter bit LOOP_PLAYBACK = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                carry_i,
    output rps_pkg::seq_state_t state_o
);
    import rps_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RECORD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RECORD: if (carry_i) state_d = SEQ_PLAY;
            SEQ_PLAY:   if (carry_i) state_d = LOOP_PLAYBACK ? SEQ_PLAY : SEQ_IDLE;
            SEQ_IDLE:   state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    assign state_o = state_q;

    a_r6_wrap_to_play: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RECORD && carry_i) |=> state_q == SEQ_PLAY);

    a_r6_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_RECORD) |=> state_q != SEQ_RECORD);

    a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE) |=> state_q == SEQ_IDLE);

    if (LOOP_PLAYBACK) begin : g_loop_chk
        a_r9_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/rps_strobe_gen.sv
`timescale 1ns/1ps
module rps_strobe_gen (
    input  logic                clk,
    input  logic                rst_n,
    input  rps_pkg::seq_state_t state_i,
    output logic                we_o,
    output logic                re_o,
    output logic                count_en_o,
    output logic                play_mode_o
);
    import rps_pkg::*;

    logic low_phase;
    assign low_phase = rst_n & ~clk;

    always_comb begin
        we_o        = 1'b0;
        re_o        = 1'b0;
        count_en_o  = 1'b0;
        play_mode_o = 1'b0;
        unique case (state_i)
            SEQ_RECORD: begin
                we_o       = low_phase;
                count_en_o = 1'b1;
            end
            SEQ_PLAY: begin
                re_o        = low_phase;
                count_en_o  = 1'b1;
                play_mode_o = 1'b1;
            end
            SEQ_IDLE: begin
                play_mode_o = 1'b1;
            end
            default: begin
                play_mode_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (rst_n) begin
            a_r4_exclusive: assert (!(we_o && re_o));
        end
    end

endmodule

// File: rtl/rps_play_capture.sv
`timescale 1ns/1ps
module rps_play_capture #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rps_pkg::seq_state_t state_i,
    input  logic [DATA_W-1:0]   rdata_i,
    output logic [DATA_W-1:0]   data_o,
    output logic                valid_o
);
    import rps_pkg::*;

    // Sampled at the rising edge that closes the read strobe's low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= (state_i == SEQ_PLAY);
            if (state_i == SEQ_PLAY) begin
                data_o <= rdata_i;
            end
        end
    end

    a_r7_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == SEQ_PLAY) |=> valid_o);

    a_r8_no_valid_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != SEQ_PLAY) |=> !valid_o);

endmodule

// File: rtl/rec_play_seq.sv
`timescale 1ns/1ps
module rec_play_seq #(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter bit LOOP_PLAYBACK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              ram_we_o,
    output logic              ram_re_o,
    output logic              play_mode_o,
    output logic              carry_o,
    output logic [DATA_W-1:0] play_data_o,
    output logic              play_valid_o
);
    import rps_pkg::*;

    seq_state_t state;
    logic       count_en;
    logic       cnt_carry;

    rps_addr_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .addr_o   (ram_addr_o),
        .carry_o  (cnt_carry)
    );

    rps_mode_fsm #(.LOOP_PLAYBACK(LOOP_PLAYBACK)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .carry_i (cnt_carry),
        .state_o (state)
    );

    rps_strobe_gen u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .we_o        (ram_we_o),
        .re_o        (ram_re_o),
        .count_en_o  (count_en),
        .play_mode_o (play_mode_o)
    );

    rps_play_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .rdata_i (ram_rdata_i),
        .data_o  (play_data_o),
        .valid_o (play_valid_o)
    );

    assign ram_wdata_o = sample_i;
    assign carry_o     = cnt_carry;

    a_r5_carry_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> count_en);

endmodule

// File: tb/tb_rec_play_seq.sv
`timescale 1ns/1ps
module tb_rec_play_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat8(input int n);
        return 8'(n * 37 + 11);
    endfunction

    function automatic logic [7:0] pat10(input int a);
        return 8'(a * 7 + (a / 256) * 3 + 5);
    endfunction

    // ---------------- main instance: 8-bit address, single pass
    logic [7:0] m_sample = 8'h00;
    logic [7:0] m_addr, m_wdata, m_pdata;
    logic [7:0] m_rdata = 8'h00;
    logic       m_we, m_re, m_mode, m_carry, m_pvalid;

    rec_play_seq #(.ADDR_W(8), .DATA_W(8), .LOOP_PLAYBACK(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .sample_i(m_sample),
        .ram_addr_o(m_addr), .ram_wdata_o(m_wdata), .ram_rdata_i(m_rdata),
        .ram_we_o(m_we), .ram_re_o(m_re), .play_mode_o(m_mode),
        .carry_o(m_carry), .play_data_o(m_pdata), .play_valid_o(m_pvalid)
    );

    logic [7:0] m_mem [256];
    int m_writes = 0;
    initial for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;

    // behavioural RAM: acts mid low phase; read data settles then holds
    always begin
        @(negedge clk);
        #2;
        if (m_we) begin
            m_mem[m_addr] = m_wdata;
            m_writes++;
        end
        if (m_re) m_rdata = m_mem[m_addr];
    end

    // ---------------- loop instance: 10-bit address, continuous replay
    logic [7:0] l_sample;
    logic [9:0] l_addr;
    logic [7:0] l_wdata, l_pdata;
    logic [7:0] l_rdata = 8'h00;
    logic       l_we, l_re, l_mode, l_carry, l_pvalid;

    always_comb l_sample = pat10(int'(l_addr));

    rec_play_seq #(.ADDR_W(10), .DATA_W(8), .LOOP_PLAYBACK(1'b1)) dut_loop (
        .clk(clk), .rst_n(rst_n), .sample_i(l_sample),
        .ram_addr_o(l_addr), .ram_wdata_o(l_wdata), .ram_rdata_i(l_rdata),
        .ram_we_o(l_we), .ram_re_o(l_re), .play_mode_o(l_mode),
        .carry_o(l_carry), .play_data_o(l_pdata), .play_valid_o(l_pvalid)
    );

    logic [7:0] l_mem [1024];
    int l_writes = 0;
    initial for (int i = 0; i < 1024; i++) l_mem[i] = 8'h00;

    always begin
        @(negedge clk);
        #2;
        if (l_we) begin
            l_mem[l_addr] = l_wdata;
            l_writes++;
        end
        if (l_re) l_rdata = l_mem[l_addr];
    end

    // ---------------- scoreboard
    logic [7:0] exp_q [$];

    task automatic drive_main();
        for (int n = 1; n < 256; n++) begin
            @(posedge clk);
            #1;
            m_sample = pat8(n);
            exp_q.push_back(pat8(n));
        end
    endtask

    task automatic monitor_main();
        for (int c = 0; c < 600; c++) begin
            int ea;
            logic [7:0] e;
            #1;
            ea = (c < 256) ? c : ((c < 512) ? c - 256 : 0);
            check(int'(m_addr) == ea, (c < 256) ? "R2 address" : ((c < 512) ? "R6 play address" : "R8 idle address"), int'(m_addr), ea);
            check(m_we == (c < 256), (c < 512) ? "R3 write strobe low phase" : "R8 idle write strobe", int'(m_we), int'(c < 256));
            check(m_re == (c >= 256 && c < 512), (c < 512) ? "R4 read strobe low phase" : "R8 idle read strobe", int'(m_re), int'(c >= 256 && c < 512));
            check(m_carry == (c < 512 && ea == 255), "R5 carry", int'(m_carry), int'(c < 512 && ea == 255));
            check(m_mode == (c >= 256), "R6 play mode", int'(m_mode), int'(c >= 256));
            if (c < 256) check(m_wdata == pat8(c), "R2 write data", int'(m_wdata), int'(pat8(c)));
            check(m_pvalid == (c >= 257 && c <= 512), (c <= 512) ? "R7 valid" : "R8 idle valid", int'(m_pvalid), int'(c >= 257 && c <= 512));
            if (m_pvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected byte", int'(m_pdata), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(m_pdata == e, "R7 playback order", int'(m_pdata), int'(e));
                end
            end
            @(posedge clk);
            #1;
            check(!m_we && !m_re, "R3 strobes low in high phase", int'({m_we, m_re}), 0);
            @(negedge clk);
        end
    endtask

    task automatic monitor_loop();
        int k = 0;
        for (int c = 0; c < 3200; c++) begin
            #1;
            check(int'(l_addr) == (c % 1024), "R10 cascaded address", int'(l_addr), c % 1024);
            check(l_carry == ((c % 1024) == 1023), "R10 carry at all ones", int'(l_carry), int'((c % 1024) == 1023));
            check(l_mode == (c >= 1024), "R9 loop mode", int'(l_mode), int'(c >= 1024));
            check(l_we == (c < 1024) && l_re == (c >= 1024), "R9 loop strobes", int'({l_we, l_re}), (c < 1024) ? 2 : 1);
            check(l_pvalid == (c >= 1025), "R9 loop valid", int'(l_pvalid), int'(c >= 1025));
            if (l_pvalid) begin
                check(l_pdata == pat10(k % 1024), "R9 replay order", int'(l_pdata), int'(pat10(k % 1024)));
                k++;
            end
            @(negedge clk);
        end
        check(k == 2175, "R9 reads across passes", k, 2175);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        #1;
        check(m_addr == 8'd0, "R1 reset address", int'(m_addr), 0);
        check(!m_we && !m_re, "R1 reset strobes", int'({m_we, m_re}), 0);
        check(m_mode == 1'b0, "R1 reset mode", int'(m_mode), 0);
        check(m_pvalid == 1'b0, "R1 reset valid", int'(m_pvalid), 0);
        @(negedge clk);
        #1;
        check(!m_we && !m_re && !l_we, "R1 no strobe in reset low phase", int'({m_we, m_re, l_we}), 0);
        @(negedge clk);
        m_sample = pat8(0);
        exp_q.push_back(pat8(0));
        rst_n = 1'b1;
        fork
            drive_main();
            monitor_main();
            monitor_loop();
        join
        check(m_writes == 256, "R6 total writes main", m_writes, 256);
        check(l_writes == 1024, "R10 total writes loop", l_writes, 1024);
        check(exp_q.size() == 0, "R7 all bytes played", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #160000;
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule